// File: doc/BRIEF.md
# Two-Phase Microstep Stepper PWM Driver

This block drives the two windings of a stepper motor in microstep mode. A position counter tracks the rotor's electrical angle in microsteps. Step strobes move it by one, and a direction input picks forward or backward travel. Ten microsteps make one full step, and four full steps make one electrical period of forty microsteps.

For each winding, the position is folded onto a quarter-period index, and the quadrant sets that winding's polarity output. The index selects a duty value. The duty comes either from a small writable table, which holds a quarter wave such as a sine quarter that can be corrected for positioning errors, or from a computed linear ramp that gives triangle-shaped quadrature currents. The X winding follows the sine of the angle and the Y winding follows the cosine. The two duties feed 8-bit PWM generators that share one free-running period counter.

The PWM and polarity outputs go to external H-bridges. A new duty or polarity only takes hold at the start of a PWM period.

Top module: `ustep_driver`

## Requirements
- R1: While reset is active, and until the first active edge after the internally synchronised release, the position is 0, both PWM outputs are low and both polarity outputs are low.
- R2: On each clock edge with `step` high, the position moves by one: it adds one when `dir` is 1 and subtracts one when `dir` is 0. It wraps between 39 and 0 in both directions. Without `step` the position holds.
- R3: An 8-bit period counter runs freely from 0 to 255. Each PWM output is high exactly while the counter is below that winding's applied duty, so a duty of 0 never drives the output high.
- R4: A winding's applied duty and polarity are reloaded only on the edge where the counter goes from 255 to 0. Steps, law changes and table writes made at other times do not alter the outputs before that edge.
- R5: For the X winding, with position p, quadrant q = p/10 and offset o = p%10, the index is o when q is 0 or 2 and 10-o when q is 1 or 3. `neg_x` is 1 for q equal to 2 or 3.
- R6: The Y winding uses the same folding applied to (p+10) mod 40, so Y leads X by a quarter period.
- R7: With `law_tri` = 0, the duty is the table entry at the folded index. The table has entries 0 to 10, all 0 after reset. A write with `tbl_we` high stores `tbl_data` at `tbl_addr`, and writes to addresses 11 to 15 are ignored.
- R8: With `law_tri` = 1, the duty is floor(index*255/10) and the table contents have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance the position by one microstep this cycle |
| dir | input | 1 | 1 = forward, 0 = backward |
| law_tri | input | 1 | 0 = table law, 1 = triangle law |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_data | input | 8 | Duty value to write |
| pos | output | 6 | Current microstep position, 0 to 39 |
| pwm_x | output | 1 | PWM for winding X |
| pwm_y | output | 1 | PWM for winding Y |
| neg_x | output | 1 | Reverse polarity for winding X |
| neg_y | output | 1 | Reverse polarity for winding Y |

## Verification
The bench builds the block with its default values: an 8-bit duty and ten microsteps per step. This gives 256-cycle PWM periods and a 40-position electrical cycle, so every quadrant fold and both wrap points can be visited in full within the run. Directed sweeps dwell a full PWM period on each position under both laws, in each direction, and across the 0/39 boundary. Random stimulus then mixes bursts of steps inside a period, law switches and table writes that include the unused addresses, so the period-boundary reload and the ignored writes are both observed at the PWM outputs.

// File: rtl/ustep_pkg.sv
`timescale 1ns/1ps
package ustep_pkg;
  localparam int NUM_PH = 2;
  localparam int PH_X   = 0;
  localparam int PH_Y   = 1;

  typedef enum logic {LAW_TABLE = 1'b0, LAW_TRIANGLE = 1'b1} law_e;

  // Angular lead of a winding in microsteps (Y leads X by a quarter period).
  function automatic int phase_offset(int ph, int usteps);
    return ph * usteps;
  endfunction
endpackage

// File: rtl/ustep_pos.sv
`timescale 1ns/1ps
module ustep_pos #(
  parameter int USTEPS = 10,
  parameter int POS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             dir,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(4 * USTEPS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (dir) pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    else     pos_d = (pos_q == '0) ? LAST : pos_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/ustep_table.sv
`timescale 1ns/1ps
module ustep_table #(
  parameter int USTEPS = 10,
  parameter int IDX_W  = 4,
  parameter int PWM_W  = 8,
  parameter int NRD    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [PWM_W-1:0]           wdata,
  input  logic [NRD-1:0][IDX_W-1:0]  raddr,
  output logic [NRD-1:0][PWM_W-1:0]  rdata
);
  localparam int ENTRIES = USTEPS + 1;

  logic [PWM_W-1:0] mem_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      rdata[r] = '0;
      for (int i = 0; i < ENTRIES; i++)
        if (raddr[r] == IDX_W'(i)) rdata[r] = mem_q[i];
    end
  end
endmodule

// File: rtl/ustep_fold.sv
`timescale 1ns/1ps
module ustep_fold #(
  parameter int USTEPS = 10,
  parameter int POS_W  = 6,
  parameter int IDX_W  = 4,
  parameter int PWM_W  = 8,
  parameter int OFFSET = 0
) (
  input  logic [POS_W-1:0] pos,
  output logic [IDX_W-1:0] idx,
  output logic             neg,
  output logic [PWM_W-1:0] tri_duty
);
  localparam int PERIOD = 4 * USTEPS;
  localparam int PW     = PWM_W + IDX_W;
  localparam int DMAX   = (1 << PWM_W) - 1;

  logic [POS_W:0]   sum;
  logic [POS_W-1:0] ph;
  logic [POS_W-1:0] off;
  logic [1:0]       quad;

  always_comb begin
    sum = {1'b0, pos} + (POS_W+1)'(OFFSET);
    if (sum >= (POS_W+1)'(PERIOD)) sum = sum - (POS_W+1)'(PERIOD);
    ph   = sum[POS_W-1:0];
    quad = 2'(ph / POS_W'(USTEPS));
    off  = ph % POS_W'(USTEPS);
    idx  = quad[0] ? IDX_W'(USTEPS) - IDX_W'(off) : IDX_W'(off);
    neg  = quad[1];
    tri_duty = PWM_W'((PW'(idx) * PW'(DMAX)) / PW'(USTEPS));
  end
endmodule

// File: rtl/ustep_pwm.sv
`timescale 1ns/1ps
module ustep_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PWM_W-1:0] cnt,
  input  logic [PWM_W-1:0] duty_d,
  input  logic             neg_d,
  output logic [PWM_W-1:0] duty_q,
  output logic             pwm,
  output logic             neg
);
  logic neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      neg_q  <= 1'b0;
    end else if (load) begin
      duty_q <= duty_d;
      neg_q  <= neg_d;
    end
  end

  assign pwm = (cnt < duty_q);
  assign neg = neg_q;
endmodule

// File: rtl/ustep_driver.sv
`timescale 1ns/1ps
module ustep_driver import ustep_pkg::*; #(
  parameter int PWM_W  = 8,
  parameter int USTEPS = 10,
  parameter int POS_W  = $clog2(4 * USTEPS),
  parameter int IDX_W  = $clog2(USTEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             dir,
  input  logic             law_tri,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [PWM_W-1:0] tbl_data,
  output logic [POS_W-1:0] pos,
  output logic             pwm_x,
  output logic             pwm_y,
  output logic             neg_x,
  output logic             neg_y
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // Shared PWM period counter.
  logic [PWM_W-1:0] cnt_q, cnt_d;
  logic             period_end;
  assign cnt_d      = cnt_q + 1'b1;
  assign period_end = &cnt_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  logic [POS_W-1:0] pos_q;
  ustep_pos #(.USTEPS(USTEPS), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_q_n), .step(step), .dir(dir), .pos(pos_q)
  );

  logic [NUM_PH-1:0][IDX_W-1:0] idx;
  logic [NUM_PH-1:0][PWM_W-1:0] tbl_rd, tri_d, duty_n, duty_app;
  logic [NUM_PH-1:0]            neg_n, pwm_v, neg_v;
  law_e                         law;
  assign law = law_e'(law_tri);

  ustep_table #(.USTEPS(USTEPS), .IDX_W(IDX_W), .PWM_W(PWM_W), .NRD(NUM_PH)) u_tbl (
    .clk(clk), .rst_n(rst_q_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(idx), .rdata(tbl_rd)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    ustep_fold #(
      .USTEPS(USTEPS), .POS_W(POS_W), .IDX_W(IDX_W), .PWM_W(PWM_W),
      .OFFSET(phase_offset(g, USTEPS))
    ) u_fold (
      .pos(pos_q), .idx(idx[g]), .neg(neg_n[g]), .tri_duty(tri_d[g])
    );

    assign duty_n[g] = (law == LAW_TRIANGLE) ? tri_d[g] : tbl_rd[g];

    ustep_pwm #(.PWM_W(PWM_W)) u_pwm (
      .clk(clk), .rst_n(rst_q_n), .load(period_end), .cnt(cnt_q),
      .duty_d(duty_n[g]), .neg_d(neg_n[g]),
      .duty_q(duty_app[g]), .pwm(pwm_v[g]), .neg(neg_v[g])
    );
  end

  assign pos   = pos_q;
  assign pwm_x = pwm_v[PH_X];
  assign pwm_y = pwm_v[PH_Y];
  assign neg_x = neg_v[PH_X];
  assign neg_y = neg_v[PH_Y];
endmodule

// File: rtl/ustep_driver_chk.sv
`timescale 1ns/1ps
module ustep_driver_chk #(
  parameter int PWM_W  = 8,
  parameter int USTEPS = 10,
  parameter int POS_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             dir,
  input logic [POS_W-1:0] pos,
  input logic [PWM_W-1:0] cnt,
  input logic [PWM_W-1:0] duty_x,
  input logic [PWM_W-1:0] duty_y,
  input logic             pwm_x,
  input logic             pwm_y,
  input logic             neg_x,
  input logic             neg_y
);
  localparam logic [POS_W-1:0] LAST = POS_W'(4 * USTEPS - 1);

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  assert_step_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir) |=> pos == (($past(pos) == LAST) ? '0 : $past(pos) + 1'b1));

  assert_step_bwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dir) |=> pos == (($past(pos) == '0) ? LAST : $past(pos) - 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_x == '0) |-> !pwm_x);

  assert_first_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && duty_y != '0) |-> pwm_y);

  assert_mid_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(duty_x) && $stable(duty_y) && $stable(neg_x) && $stable(neg_y)));
endmodule

bind ustep_driver ustep_driver_chk #(.PWM_W(PWM_W), .USTEPS(USTEPS), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .step(step), .dir(dir), .pos(pos), .cnt(cnt_q),
  .duty_x(duty_app[0]), .duty_y(duty_app[1]),
  .pwm_x(pwm_x), .pwm_y(pwm_y), .neg_x(neg_x), .neg_y(neg_y)
);

// File: tb/tb_ustep_driver.sv
`timescale 1ns/1ps
module tb_ustep_driver;
  localparam int USTEPS = 10;
  localparam int PERIOD = 4 * USTEPS;
  localparam int DMAX   = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 1'b0, dir = 1'b0, law_tri = 1'b0, tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic [5:0] pos;
  logic pwm_x, pwm_y, neg_x, neg_y;

  always #2 clk = ~clk;

  ustep_driver dut (
    .clk(clk), .rst_n(rst_n), .step(step), .dir(dir), .law_tri(law_tri),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .pos(pos), .pwm_x(pwm_x), .pwm_y(pwm_y), .neg_x(neg_x), .neg_y(neg_y)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  string tag = "R3";

  int m_pos = 0, m_cnt = 0, m_dx = 0, m_dy = 0;
  bit m_nx = 1'b0, m_ny = 1'b0;
  int m_tbl [USTEPS+1];

  function automatic int fold(int p);
    int q = p / USTEPS;
    int o = p % USTEPS;
    return (q % 2 == 1) ? USTEPS - o : o;
  endfunction

  function automatic int duty_of(int p, bit tri_law);
    int i = fold(p);
    return tri_law ? (i * DMAX) / USTEPS : m_tbl[i];
  endfunction

  function automatic bit neg_of(int p);
    return (p / USTEPS) >= 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare at a falling edge, drive the next inputs, advance the model.
  task automatic cyc(bit s, bit d, bit lt, bit we, int a, int v);
    chk("R2", "pos", pos, m_pos);
    chk(tag, "pwm_x", pwm_x, (m_cnt < m_dx) ? 1 : 0);
    chk(tag, "pwm_y", pwm_y, (m_cnt < m_dy) ? 1 : 0);
    chk("R5", "neg_x", neg_x, m_nx);
    chk("R6", "neg_y", neg_y, m_ny);
    step = s; dir = d; law_tri = lt; tbl_we = we;
    tbl_addr = 4'(a); tbl_data = 8'(v);
    if (m_cnt == DMAX) begin
      int py;
      py   = (m_pos + USTEPS) % PERIOD;
      m_dx = duty_of(m_pos, lt);
      m_dy = duty_of(py, lt);
      m_nx = neg_of(m_pos);
      m_ny = neg_of(py);
    end
    if (s) m_pos = d ? (m_pos + 1) % PERIOD : (m_pos + PERIOD - 1) % PERIOD;
    if (we && a <= USTEPS) m_tbl[a] = v;
    m_cnt = (m_cnt + 1) % 256;
    @(negedge clk);
  endtask

  task automatic sweep(int n, bit d, bit lt, int dwell);
    for (int k = 0; k < n; k++) begin
      cyc(1'b1, d, lt, 1'b0, 0, 0);
      for (int j = 0; j < dwell; j++) cyc(1'b0, d, lt, 1'b0, 0, 0);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i <= USTEPS; i++) m_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "pos", pos, 0);
    chk("R1", "pwm_x", pwm_x, 0);
    chk("R1", "pwm_y", pwm_y, 0);
    chk("R1", "neg_x", neg_x, 0);
    chk("R1", "neg_y", neg_y, 0);

    // R7: load a sine quarter, plus ignored writes to addresses above 10
    tag = "R3 R4 R7";
    for (int i = 0; i <= USTEPS; i++)
      cyc(1'b0, 1'b1, 1'b0, 1'b1, i,
          $rtoi(255.0 * $sin(i * 3.14159265358979 / (2.0 * USTEPS)) + 0.5));
    for (int a = USTEPS + 1; a < 16; a++) cyc(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h5A);

    // R5 R6: forward then backward sweeps under the table law, crossing 39/0
    tag = "R3 R4 R5 R6 R7";
    sweep(45, 1'b1, 1'b0, 299);
    sweep(50, 1'b0, 1'b0, 299);

    // R8: triangle law, both directions
    tag = "R3 R4 R8";
    sweep(20, 1'b1, 1'b1, 299);
    sweep(30, 1'b0, 1'b1, 299);

    // R4: step burst within one period must not show until the period ends
    tag = "R4";
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
    for (int k = 0; k < 300; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 0, 0);

    // Random mix: steps, direction, law switches, table writes incl. ignored ones
    tag = "R2 R3 R4 R5 R6 R7 R8";
    begin
      bit lt = 1'b0;
      bit d  = 1'b1;
      for (int k = 0; k < 60000; k++) begin
        bit s, we;
        if ($urandom_range(0, 1999) == 0) lt = ~lt;
        if ($urandom_range(0, 299) == 0) d = ~d;
        s  = ($urandom_range(0, 63) == 0);
        we = ($urandom_range(0, 499) == 0);
        cyc(s, d, lt, we, $urandom_range(0, 15), $urandom_range(0, 255));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule